// File: doc/BRIEF.md
# Multi-Level Channel Service Scheduler

This block chooses which of sixteen timer channels a single shared service engine handles next. A channel can have up to four kinds of service pending at once: a host-issued service call, a link raised by another channel, a match event and a capture event. Each kind arrives as a one-cycle pulse and is latched until it is served. The host gives every channel a two-bit priority setting, which can disable the channel or place it at the low, middle or high level.

The scheduler runs without any help from the host. Whenever the engine shows it is ready and no grant is outstanding, the scheduler picks one channel. It chooses the level first, using a fairness rule that stops the lower levels from starving. It then chooses a channel inside that level in round-robin order, and then the most urgent pending reason on that channel. It presents the channel number and the reason code, and it clears only that one pending bit. The grant stays on the outputs until the engine drops its ready line for one cycle.

Top module: `svc_sched`

## Requirements
- R1: Reset clears every pending bit and deasserts `gnt_valid`. Events latched before reset are never granted afterwards.
- R2: A grant is raised only at a clock edge where `eng_ready` is high, `gnt_valid` is low and at least one enabled channel has a pending reason. `gnt_valid` rises at that same edge.
- R3: While `gnt_valid` is high and `eng_ready` stays high, `gnt_valid`, `gnt_chan` and `gnt_why` hold their values. The first edge at which `eng_ready` is low drops `gnt_valid`.
- R4: A channel whose priority field `prio_cfg[2c+1:2c]` is 00 is never granted. Its pending bits are kept, and it becomes eligible as soon as its field is non-zero.
- R5: The priority codes are 11 high, 10 middle and 01 low. When no fairness rule applies, the highest level with an eligible channel wins.
- R6: Inside a level, channels are scanned round-robin, starting at the channel one above the last one granted at that level and wrapping from 15 to 0. After reset every level starts its scan at channel 0.
- R7: High-level grants are counted, and the count saturates at four. A middle-level grant clears the count. When the count is four and a middle channel is eligible, the middle level is granted.
- R8: Middle-level grants are counted, and the count saturates at two. A low-level grant clears the count. When the count is two and a low channel is eligible, the low level is granted. This rule takes precedence over R7.
- R9: On the chosen channel, the reason is picked in the order host (code 0), link (code 1), match (code 2), capture (code 3). Only that reason's pending bit is cleared, and the others are served by later grants.
- R10: Pending bits are sticky. A pulse becomes eligible from the cycle after it arrives. A pulse that arrives in the same cycle its bit is cleared by a grant leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_host | input | 16 | Host service pulse, one bit per channel |
| ev_link | input | 16 | Channel link pulse, one bit per channel |
| ev_match | input | 16 | Match event pulse, one bit per channel |
| ev_capt | input | 16 | Capture event pulse, one bit per channel |
| prio_cfg | input | 32 | Two-bit priority per channel; channel c uses bits 2c+1:2c |
| eng_ready | input | 1 | Service engine is ready; a low cycle accepts the current grant |
| gnt_valid | output | 1 | A grant is being presented |
| gnt_chan | output | 4 | Granted channel number |
| gnt_why | output | 2 | Granted reason code (0 host, 1 link, 2 match, 3 capture) |

## Verification
The bench targets the collision of both fairness counters. A middle burst and a high burst are set up so that the low and middle forcing rules apply at once. A design that checks the rules in the wrong order grants the middle channel before the low one. Round-robin wrap-around is run twice across the same set of channels. If the pointer were reset on every grant, or taken from the wrong level, the second round would start at the lowest channel instead of the one after the last grant. The bench also pulses a reason in the very cycle its bit is cleared, disables a channel that has work pending and then enables it, and resets over latched events. Errors in these cases would show up as a lost second grant, a grant to a disabled channel, or a stale grant after reset.

// File: rtl/svc_sched_pkg.sv
package svc_sched_pkg;

  localparam int NRSN = 4;

  typedef enum logic [1:0] {
    LVL_OFF = 2'b00,
    LVL_LO  = 2'b01,
    LVL_MD  = 2'b10,
    LVL_HI  = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    RSN_HOST = 2'd0,
    RSN_LINK = 2'd1,
    RSN_MTCH = 2'd2,
    RSN_CAPT = 2'd3
  } rsn_e;

  // Lowest set bit wins: host before link before match before capture.
  function automatic logic [1:0] rsn_pick(input logic [NRSN-1:0] bits);
    logic [1:0] r;
    r = 2'd0;
    for (int i = NRSN - 1; i >= 0; i--) begin
      if (bits[i]) r = 2'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/svc_pend_store.sv
module svc_pend_store
  import svc_sched_pkg::*;
#(
  parameter int NCH = 16,
  localparam int W = NCH * NRSN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] pend
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [NRSN-1:0] bits_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q <= '0;
      else        bits_q <= (bits_q & ~clr_vec[ch*NRSN +: NRSN]) | set_vec[ch*NRSN +: NRSN];
    end
    assign pend[ch*NRSN +: NRSN] = bits_q;
  end

endmodule

// File: rtl/svc_rr_lane.sv
module svc_rr_lane #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           adv,
  output logic           hit,
  output logic [CW-1:0]  pick
);

  logic [CW-1:0] last_q;

  // Returns {found, index}; the scan starts one above the last grant.
  function automatic logic [CW:0] rr_scan(input logic [NCH-1:0] r, input logic [CW-1:0] last);
    logic          f;
    logic [CW-1:0] idx;
    int            c;
    f   = 1'b0;
    idx = '0;
    for (int k = 1; k <= NCH; k++) begin
      c = (int'(last) + k) % NCH;
      if (!f && r[c]) begin
        f   = 1'b1;
        idx = CW'(c);
      end
    end
    return {f, idx};
  endfunction

  assign {hit, pick} = rr_scan(req, last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   last_q <= CW'(NCH - 1);
    else if (adv) last_q <= pick;
  end

endmodule

// File: rtl/svc_level_ctl.sv
module svc_level_ctl
  import svc_sched_pkg::*;
#(
  parameter int HI_BURST = 4,
  parameter int MD_BURST = 2,
  localparam int HW = $clog2(HI_BURST + 1),
  localparam int MW = $clog2(MD_BURST + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic has_lo,
  input  logic has_md,
  input  logic has_hi,
  input  logic fire,
  output lvl_e sel_lvl,
  output logic any_has,
  output logic hi_full,
  output logic md_full
);

  logic [HW-1:0] hi_cnt;
  logic [MW-1:0] md_cnt;

  // Low forcing outranks middle forcing, which outranks plain level order.
  function automatic lvl_e pick_level(input logic lo, input logic md, input logic hi,
                                      input logic hf, input logic mf);
    if (mf && lo)      return LVL_LO;
    else if (hf && md) return LVL_MD;
    else if (hi)       return LVL_HI;
    else if (md)       return LVL_MD;
    else if (lo)       return LVL_LO;
    else               return LVL_OFF;
  endfunction

  assign hi_full = (hi_cnt == HW'(HI_BURST));
  assign md_full = (md_cnt == MW'(MD_BURST));
  assign any_has = has_lo | has_md | has_hi;
  assign sel_lvl = pick_level(has_lo, has_md, has_hi, hi_full, md_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      md_cnt <= '0;
    end else if (fire) begin
      unique case (sel_lvl)
        LVL_HI: if (!hi_full) hi_cnt <= hi_cnt + 1'b1;
        LVL_MD: begin
          hi_cnt <= '0;
          if (!md_full) md_cnt <= md_cnt + 1'b1;
        end
        LVL_LO:  md_cnt <= '0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/svc_sched.sv
module svc_sched
  import svc_sched_pkg::*;
#(
  parameter int NCH = 16,
  parameter int HI_BURST = 4,
  parameter int MD_BURST = 2,
  localparam int CW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   ev_host,
  input  logic [NCH-1:0]   ev_link,
  input  logic [NCH-1:0]   ev_match,
  input  logic [NCH-1:0]   ev_capt,
  input  logic [2*NCH-1:0] prio_cfg,
  input  logic             eng_ready,
  output logic             gnt_valid,
  output logic [CW-1:0]    gnt_chan,
  output logic [1:0]       gnt_why
);

  localparam int PW = NCH * NRSN;

  logic [PW-1:0]  set_vec, clr_vec, pend_vec;
  logic [NCH-1:0] lvl_req [4];
  logic [3:0]     lane_hit;
  logic [CW-1:0]  lane_pick [4];

  // Named internal events, observed by the checker.
  lvl_e          sel_lvl;
  logic [1:0]    lvl_idx;
  logic [CW-1:0] sel_chan;
  logic [1:0]    sel_why;
  logic          fire, any_has, hi_full, md_full, has_lo;

  // Pack the pulses as channel-major groups of four: host, link, match, capture.
  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      set_vec[ch*NRSN + 0] = ev_host[ch];
      set_vec[ch*NRSN + 1] = ev_link[ch];
      set_vec[ch*NRSN + 2] = ev_match[ch];
      set_vec[ch*NRSN + 3] = ev_capt[ch];
    end
  end

  svc_pend_store #(.NCH(NCH)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .pend   (pend_vec)
  );

  // Per-level eligibility: the channel's setting matches the level and work is pending.
  always_comb begin
    for (int l = 0; l < 4; l++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        lvl_req[l][ch] = (l != 0) && (prio_cfg[ch*2 +: 2] == 2'(l)) && (|pend_vec[ch*NRSN +: NRSN]);
      end
    end
  end

  assign lane_hit[0]  = 1'b0;
  assign lane_pick[0] = '0;

  for (genvar l = 1; l < 4; l++) begin : g_lane
    svc_rr_lane #(.NCH(NCH)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (lvl_req[l]),
      .adv  (fire && (lvl_idx == 2'(l))),
      .hit  (lane_hit[l]),
      .pick (lane_pick[l])
    );
  end

  assign has_lo = lane_hit[1];

  svc_level_ctl #(.HI_BURST(HI_BURST), .MD_BURST(MD_BURST)) u_lvl (
    .clk    (clk),
    .rst_n  (rst_n),
    .has_lo (lane_hit[1]),
    .has_md (lane_hit[2]),
    .has_hi (lane_hit[3]),
    .fire   (fire),
    .sel_lvl(sel_lvl),
    .any_has(any_has),
    .hi_full(hi_full),
    .md_full(md_full)
  );

  assign lvl_idx  = sel_lvl;
  assign sel_chan = lane_pick[lvl_idx];
  assign sel_why  = rsn_pick(pend_vec[{sel_chan, 2'b00} +: NRSN]);
  assign fire     = !gnt_valid && eng_ready && any_has;

  always_comb begin
    clr_vec = '0;
    if (fire) clr_vec[{sel_chan, sel_why}] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_chan  <= '0;
      gnt_why   <= '0;
    end else if (fire) begin
      gnt_valid <= 1'b1;
      gnt_chan  <= sel_chan;
      gnt_why   <= sel_why;
    end else if (gnt_valid && !eng_ready) begin
      gnt_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/svc_sched_chk.sv
module svc_sched_chk #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH),
  localparam int PW = NCH * 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eng_ready,
  input logic [2*NCH-1:0] prio_cfg,
  input logic             gnt_valid,
  input logic [CW-1:0]    gnt_chan,
  input logic [1:0]       gnt_why,
  input logic             fire,
  input logic [1:0]       sel_lvl,
  input logic [CW-1:0]    sel_chan,
  input logic [1:0]       sel_why,
  input logic [PW-1:0]    clr_vec,
  input logic [PW-1:0]    pend_vec,
  input logic             md_full,
  input logic             has_lo
);

  logic [1:0]    chosen_prio;
  logic          chosen_bit;
  logic [PW-1:0] kept_q;

  assign chosen_prio = prio_cfg[{sel_chan, 1'b0} +: 2];
  assign chosen_bit  = pend_vec[{sel_chan, sel_why}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kept_q <= '0;
    else        kept_q <= pend_vec & ~clr_vec;
  end

  p_rise_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> $past(eng_ready));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (gnt_valid && gnt_chan == $past(sel_chan) && gnt_why == $past(sel_why)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && eng_ready) |=> (gnt_valid && $stable(gnt_chan) && $stable(gnt_why)));

  p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !eng_ready) |=> !gnt_valid);

  p_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> chosen_prio != 2'b00);

  p_level_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> chosen_prio == sel_lvl);

  p_forced_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && md_full && has_lo) |-> sel_lvl == 2'b01);

  p_reason_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> chosen_bit);

  p_single_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $countones(clr_vec) == 1);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (kept_q & ~pend_vec) == '0);

endmodule

bind svc_sched svc_sched_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .eng_ready(eng_ready),
  .prio_cfg (prio_cfg),
  .gnt_valid(gnt_valid),
  .gnt_chan (gnt_chan),
  .gnt_why  (gnt_why),
  .fire     (fire),
  .sel_lvl  (lvl_idx),
  .sel_chan (sel_chan),
  .sel_why  (sel_why),
  .clr_vec  (clr_vec),
  .pend_vec (pend_vec),
  .md_full  (md_full),
  .has_lo   (has_lo)
);

// File: tb/svc_sched_tb.sv
`timescale 1ns/1ps
module svc_sched_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev_host = '0, ev_link = '0, ev_match = '0, ev_capt = '0;
  logic [31:0] prio_cfg = '0;
  logic        eng_ready = 1'b0;
  logic        gnt_valid;
  logic [3:0]  gnt_chan;
  logic [1:0]  gnt_why;

  always #2 clk = ~clk;

  svc_sched u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_host(ev_host), .ev_link(ev_link), .ev_match(ev_match), .ev_capt(ev_capt),
    .prio_cfg(prio_cfg), .eng_ready(eng_ready),
    .gnt_valid(gnt_valid), .gnt_chan(gnt_chan), .gnt_why(gnt_why)
  );

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit    auto_eng = 1'b1;
  bit    done = 1'b0;
  bit    prev_v = 1'b0;
  int    log_q[$];

  // ---------------- behavioural reference ----------------
  bit [3:0] m_pend [16];
  int       m_last [4];
  int       m_hc, m_mc, m_gc, m_gw;
  bit       m_gv;
  int       hs [4];
  int       lv, pc, pr;
  bit       go;

  function automatic bit ev_at(int ch, int r);
    case (r)
      0: return ev_host[ch];
      1: return ev_link[ch];
      2: return ev_match[ch];
      default: return ev_capt[ch];
    endcase
  endfunction

  function automatic int pri_of(int ch);
    return int'(prio_cfg[ch*2 +: 2]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 16; c++) m_pend[c] = '0;
      for (int l = 0; l < 4; l++) m_last[l] = 15;
      m_hc = 0; m_mc = 0; m_gv = 0; m_gc = 0; m_gw = 0;
    end else begin
      for (int l = 0; l < 4; l++) hs[l] = 0;
      for (int c = 0; c < 16; c++)
        if (pri_of(c) != 0 && m_pend[c] != 0) hs[pri_of(c)] = 1;
      go = !m_gv && eng_ready && (hs[1] + hs[2] + hs[3] > 0);
      if (m_gv && !eng_ready) m_gv = 0;
      if (go) begin
        if (m_mc >= 2 && hs[1] == 1)      lv = 1;
        else if (m_hc >= 4 && hs[2] == 1) lv = 2;
        else if (hs[3] == 1)              lv = 3;
        else if (hs[2] == 1)              lv = 2;
        else                              lv = 1;
        pc = -1;
        for (int k = 1; k <= 16; k++) begin
          int c;
          c = (m_last[lv] + k) % 16;
          if (pc < 0 && pri_of(c) == lv && m_pend[c] != 0) pc = c;
        end
        pr = -1;
        for (int r = 0; r < 4; r++) if (pr < 0 && m_pend[pc][r]) pr = r;
        m_pend[pc][pr] = 1'b0;
        m_last[lv] = pc;
        if (lv == 3) m_hc = (m_hc < 4) ? m_hc + 1 : 4;
        if (lv == 2) begin m_hc = 0; m_mc = (m_mc < 2) ? m_mc + 1 : 2; end
        if (lv == 1) m_mc = 0;
        m_gv = 1; m_gc = pc; m_gw = pr;
      end
      for (int c = 0; c < 16; c++)
        for (int r = 0; r < 4; r++) if (ev_at(c, r)) m_pend[c][r] = 1'b1;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic cyc();
    int act, exp;
    @(posedge clk);
    #1;
    act = gnt_valid ? (64 + int'(gnt_chan) * 4 + int'(gnt_why)) : 0;
    exp = m_gv ? (64 + m_gc * 4 + m_gw) : 0;
    check({tag, " model compare"}, act, exp);
    if (gnt_valid && !prev_v) log_q.push_back(int'(gnt_chan) * 4 + int'(gnt_why));
    prev_v = gnt_valid;
    ev_host = '0; ev_link = '0; ev_match = '0; ev_capt = '0;
    if (auto_eng) eng_ready = !m_gv;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse(int ch, int r);
    case (r)
      0: ev_host[ch] = 1'b1;
      1: ev_link[ch] = 1'b1;
      2: ev_match[ch] = 1'b1;
      default: ev_capt[ch] = 1'b1;
    endcase
  endtask

  task automatic set_pri(int ch, int code);
    prio_cfg[ch*2 +: 2] = 2'(code);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ev_host = '0; ev_link = '0; ev_match = '0; ev_capt = '0;
    cyc(); cyc();
    check("R1 valid low in reset", int'(gnt_valid), 0);
    rst_n = 1'b1;
    log_q.delete();
  endtask

  task automatic expect_log(string what, input int e[$]);
    check({what, " grant count"}, log_q.size(), e.size());
    for (int i = 0; i < e.size(); i++)
      check({what, " grant chan*4+reason"}, (i < log_q.size()) ? log_q[i] : -1, e[i]);
    log_q.delete();
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int e[$];

    // R1: reset state, and events latched before a reset are lost
    tag = "R1"; auto_eng = 1'b1; eng_ready = 1'b0;
    do_reset();
    set_pri(2, 3); auto_eng = 1'b0; eng_ready = 1'b0;
    pulse(2, 0); cyc(); cyc();
    do_reset();
    auto_eng = 1'b1; eng_ready = 1'b1;
    run(6);
    e = {}; expect_log("R1 no stale grant", e);
    check("R1 valid stays low", int'(gnt_valid), 0);

    // R9: reason order on one channel, one bit cleared per grant
    tag = "R9"; prio_cfg = '0; do_reset();
    set_pri(5, 3); eng_ready = 1'b1;
    for (int r = 0; r < 4; r++) pulse(5, r);
    run(12);
    e = {5*4+0, 5*4+1, 5*4+2, 5*4+3}; expect_log("R9 reason order", e);

    // R6: round-robin with wrap and pointer continuation
    tag = "R6"; prio_cfg = '0; do_reset();
    set_pri(2, 3); set_pri(7, 3); set_pri(12, 3); set_pri(13, 3); eng_ready = 1'b1;
    pulse(2, 2); pulse(7, 2); pulse(12, 2);
    run(10);
    pulse(2, 2); pulse(7, 2); pulse(12, 2); pulse(13, 2);
    run(12);
    e = {2*4+2, 7*4+2, 12*4+2, 13*4+2, 2*4+2, 7*4+2, 12*4+2}; expect_log("R6 round robin", e);

    // R5: plain level order
    tag = "R5"; prio_cfg = '0; do_reset();
    set_pri(1, 1); set_pri(3, 2); set_pri(9, 3); eng_ready = 1'b1;
    pulse(1, 3); pulse(3, 3); pulse(9, 3);
    run(10);
    e = {9*4+3, 3*4+3, 1*4+3}; expect_log("R5 level order", e);

    // R7: middle forced after four high grants
    tag = "R7"; prio_cfg = '0; do_reset();
    for (int c = 0; c < 6; c++) begin set_pri(c, 3); pulse(c, 0); end
    set_pri(8, 2); pulse(8, 0); eng_ready = 1'b1;
    run(18);
    e = {0, 4, 8, 12, 32, 16, 20}; expect_log("R7 middle forcing", e);

    // R8: low forcing beats middle forcing when both are due
    tag = "R8"; prio_cfg = '0; do_reset();
    for (int c = 0; c < 5; c++) set_pri(c, 3);
    set_pri(8, 2); set_pri(9, 2); set_pri(10, 2); set_pri(14, 1); eng_ready = 1'b1;
    pulse(8, 1); pulse(9, 1);
    run(6);
    for (int c = 0; c < 4; c++) pulse(c, 2);
    run(10);
    pulse(10, 3); pulse(14, 3); pulse(4, 3);
    run(8);
    e = {8*4+1, 9*4+1, 0*4+2, 1*4+2, 2*4+2, 3*4+2, 14*4+3, 10*4+3, 4*4+3};
    expect_log("R8 low precedence", e);

    // R4: disabled channel keeps its work but is never granted
    tag = "R4"; prio_cfg = '0; do_reset();
    eng_ready = 1'b1;
    pulse(6, 1);
    run(8);
    e = {}; expect_log("R4 disabled not granted", e);
    check("R4 valid low while disabled", int'(gnt_valid), 0);
    set_pri(6, 1);
    run(4);
    e = {6*4+1}; expect_log("R4 granted once enabled", e);

    // R2, R3, R10: ready gating, hold, re-pulse at the clearing edge
    tag = "R10"; prio_cfg = '0; do_reset();
    set_pri(3, 3); auto_eng = 1'b0; eng_ready = 1'b0;
    pulse(3, 0); cyc();
    run(3);
    check("R2 no grant while not ready", int'(gnt_valid), 0);
    eng_ready = 1'b1; pulse(3, 0); cyc();
    check("R2 grant at ready edge", gnt_valid ? int'(gnt_chan) : -1, 3);
    run(3);
    check("R3 grant held while ready", gnt_valid ? int'(gnt_chan) * 4 + int'(gnt_why) : -1, 12);
    eng_ready = 1'b0; cyc();
    check("R3 valid drops after low ready", int'(gnt_valid), 0);
    auto_eng = 1'b1; eng_ready = 1'b1;
    run(6);
    e = {12, 12}; expect_log("R10 sticky re-pulse", e);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (%s): actual=hung expected=finished", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule